// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block joins two parallel buses, called A and B, through two independent storage banks. One bank carries data from A toward B and the other carries data from B toward A. Each direction has three active-low controls of its own: a bank enable, a load control and a drive control. While a bank is enabled and loading, it is transparent, and its source bus flows straight through to the far side. When loading stops, the bank keeps the last value it captured. The drive control decides whether the stored or live value is placed on the destination bus.

Each bus is modelled as an input vector, an output vector and a per-bit output-enable vector, so the block fits inside a synthesized chip with no true three-state pins. A deasserted enable bit stands for high impedance. Storage is clocked: a transparent bank samples its source on every rising clock edge. Its output shows the live source combinationally. A synchronous reset clears both banks to zero. A flag is raised when both directions drive at once, and the block does not try to resolve that case.

Top module: `xcvr_latched_bidir`

## Requirements
- R1: While rst_n is low at a rising clock edge, both banks are cleared to zero. After reset, a bank that is driven but not loading presents 0 on its destination bus.
- R2: While a direction's bank enable (ab_en_n or ba_en_n) is 1, its destination enable vector is all zeros, and its bank keeps its contents whatever the load control and source data do.
- R3: While a direction's drive control (ab_drive_n or ba_drive_n) is 1, its destination enable vector is all zeros.
- R4: With bank enable, load and drive all 0, the destination output equals the live source input in the same cycle (flow-through).
- R5: When the load control rises to 1, the bank holds the source value it sampled at the last rising edge while transparent. Later source changes do not reach the output.
- R6: While the load control is 1, the stored value does not change, whatever the source data is.
- R7: With bank enable and drive control both 0, every bit of the destination enable vector is 1. When the bank is not loading, the destination output equals the stored value.
- R8: The B-to-A direction (b_in to a_out/a_oe under ba_en_n, ba_load_n, ba_drive_n) behaves the same way as the A-to-B direction.
- R9: clash is 1 exactly when both directions drive at once, that is, when both destination enable vectors are nonzero.
- R10: While a direction is not driving, its output data vector is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; transparent banks sample on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears both banks |
| ab_en_n | input | 1 | A-to-B bank enable, active low |
| ab_load_n | input | 1 | A-to-B load control, active low (0 = transparent) |
| ab_drive_n | input | 1 | A-to-B drive control, active low |
| ba_en_n | input | 1 | B-to-A bank enable, active low |
| ba_load_n | input | 1 | B-to-A load control, active low (0 = transparent) |
| ba_drive_n | input | 1 | B-to-A drive control, active low |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Data driven toward bus A |
| a_oe | output | W | Per-bit drive enable for bus A (0 = high impedance) |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Data driven toward bus B |
| b_oe | output | W | Per-bit drive enable for bus B (0 = high impedance) |
| clash | output | 1 | Both directions driving at once |

## Verification
The assertions assume that the controls and bus inputs change only between clock edges. They also assume that reset is held for at least one rising edge before release, so that the hold checks never compare against pre-reset state. The stimulus meets both assumptions. Every input is applied one time unit after a rising edge, and the source data is kept steady across the edge at which the load control rises. The flow-through and hold properties therefore depend only on the block's registered state and its current inputs.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef struct packed {
    logic en_n;
    logic load_n;
    logic drive_n;
  } xcvr_ctl_t;

  function automatic logic ctl_transparent(xcvr_ctl_t c);
    return !c.en_n && !c.load_n;
  endfunction

  function automatic logic ctl_driving(xcvr_ctl_t c);
    return !c.en_n && !c.drive_n;
  endfunction

endpackage

// File: rtl/xcvr_store_bank.sv
module xcvr_store_bank #(
  parameter int W         = 8,
  parameter bit HAS_RESET = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] src,
  output logic [W-1:0] held
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (HAS_RESET) begin : g_rst
      always_ff @(posedge clk) begin
        if (!rst_n)       held[i] <= 1'b0;
        else if (capture) held[i] <= src[i];
      end
    end else begin : g_norst
      always_ff @(posedge clk) begin
        if (capture) held[i] <= src[i];
      end
    end
  end

endmodule

// File: rtl/xcvr_drive_stage.sv
module xcvr_drive_stage #(
  parameter int W = 8
) (
  input  logic         pass,
  input  logic         drive,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] dst_out,
  output logic [W-1:0] dst_oe
);

  logic [W-1:0] view;

  always_comb begin
    view    = pass ? live : held;
    dst_out = drive ? view : '0;
    dst_oe  = {W{drive}};
  end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W         = 8,
  parameter bit HAS_RESET = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  xcvr_ctl_t    ctl,
  input  logic [W-1:0] src,
  output logic [W-1:0] dst_out,
  output logic [W-1:0] dst_oe,
  output logic         driving
);

  logic         pass;
  logic [W-1:0] held;

  assign pass    = ctl_transparent(ctl);
  assign driving = ctl_driving(ctl);

  xcvr_store_bank #(.W(W), .HAS_RESET(HAS_RESET)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (pass),
    .src     (src),
    .held    (held)
  );

  xcvr_drive_stage #(.W(W)) i_drive (
    .pass    (pass),
    .drive   (driving),
    .live    (src),
    .held    (held),
    .dst_out (dst_out),
    .dst_oe  (dst_oe)
  );

endmodule

// File: rtl/xcvr_latched_bidir.sv
module xcvr_latched_bidir
  import xcvr_pkg::*;
#(
  parameter int W         = 8,
  parameter bit HAS_RESET = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ab_en_n,
  input  logic         ab_load_n,
  input  logic         ab_drive_n,
  input  logic         ba_en_n,
  input  logic         ba_load_n,
  input  logic         ba_drive_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic         clash
);

  localparam int NDIR = 2;

  xcvr_ctl_t    ctl   [NDIR];
  logic [W-1:0] src   [NDIR];
  logic [W-1:0] dout  [NDIR];
  logic [W-1:0] doe   [NDIR];
  logic [NDIR-1:0] drv;

  // index 0: A toward B, index 1: B toward A
  assign ctl[0] = '{en_n: ab_en_n, load_n: ab_load_n, drive_n: ab_drive_n};
  assign ctl[1] = '{en_n: ba_en_n, load_n: ba_load_n, drive_n: ba_drive_n};
  assign src[0] = a_in;
  assign src[1] = b_in;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_lane #(.W(W), .HAS_RESET(HAS_RESET)) i_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl[d]),
      .src     (src[d]),
      .dst_out (dout[d]),
      .dst_oe  (doe[d]),
      .driving (drv[d])
    );
  end

  assign b_out = dout[0];
  assign b_oe  = doe[0];
  assign a_out = dout[1];
  assign a_oe  = doe[1];
  assign clash = &drv;

endmodule

// File: rtl/xcvr_latched_bidir_chk.sv
module xcvr_latched_bidir_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ab_en_n,
  input logic         ab_load_n,
  input logic         ab_drive_n,
  input logic         ba_en_n,
  input logic         ba_load_n,
  input logic         ba_drive_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic         clash
);

  AST_AB_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ab_en_n |-> (b_oe == '0)); // R2
  AST_OE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_drive_n |-> (b_oe == '0)) and (ba_drive_n |-> (a_oe == '0))); // R3
  AST_AB_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_en_n && !ab_load_n && !ab_drive_n) |-> (b_out == a_in)); // R4
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_en_n && ab_load_n && !ab_drive_n &&
     $past(!ab_en_n && ab_load_n && !ab_drive_n)) |-> $stable(b_out)); // R6
  AST_AB_FULL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_en_n && !ab_drive_n) |-> (b_oe == '1)); // R7
  AST_BA_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_en_n && !ba_load_n && !ba_drive_n) |-> (a_out == b_in && a_oe == '1)); // R8
  AST_CLASH_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> (a_oe != '0 && b_oe != '0)); // R9
  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((b_oe == '0) |-> (b_out == '0)) and ((a_oe == '0) |-> (a_out == '0))); // R10

endmodule

bind xcvr_latched_bidir xcvr_latched_bidir_chk #(.W(W)) i_chk (.*);

// File: tb/test_xcvr_latched_bidir.sv
module test_xcvr_latched_bidir;

  localparam int W      = 8;
  localparam int PERIOD = 10;

  typedef struct {
    logic [W-1:0] b_out, b_oe, a_out, a_oe;
    logic         clash;
    string        tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ab_en_n = 1, ab_load_n = 1, ab_drive_n = 1;
  logic ba_en_n = 1, ba_load_n = 1, ba_drive_n = 1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic clash;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  // bench model state
  logic [W-1:0] m_ab = '0, m_ba = '0;
  bit p_rst = 1'b1, p_ab_t = 1'b0, p_ba_t = 1'b0;
  logic [W-1:0] p_a = '0, p_b = '0;

  always #(PERIOD/2) clk = ~clk;

  xcvr_latched_bidir #(.W(W)) i_xcvr_latched_bidir (.*);

  task automatic step(input bit rst, input bit aen, input bit ald, input bit adr,
                      input bit ben, input bit bld, input bit bdr,
                      input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    exp_t e;
    bit abt, bat, abd, bad;
    @(posedge clk);
    if (p_rst) begin m_ab = '0; m_ba = '0; end
    else begin
      if (p_ab_t) m_ab = p_a;
      if (p_ba_t) m_ba = p_b;
    end
    #1;
    rst_n = !rst;
    ab_en_n = aen; ab_load_n = ald; ab_drive_n = adr;
    ba_en_n = ben; ba_load_n = bld; ba_drive_n = bdr;
    a_in = a; b_in = b;
    abt = !aen && !ald; bat = !ben && !bld;
    abd = !aen && !adr; bad = !ben && !bdr;
    e.b_oe  = {W{abd}};
    e.a_oe  = {W{bad}};
    e.b_out = abd ? (abt ? a : m_ab) : '0;
    e.a_out = bad ? (bat ? b : m_ba) : '0;
    e.clash = abd && bad;
    e.tag   = tag;
    q.push_back(e);
    p_rst = rst; p_ab_t = abt; p_ba_t = bat; p_a = a; p_b = b;
  endtask

  task automatic cmp(input string tag, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        cmp(e.tag, "b_out", b_out, e.b_out);
        cmp(e.tag, "b_oe",  b_oe,  e.b_oe);
        cmp(e.tag, "a_out", a_out, e.a_out);
        cmp(e.tag, "a_oe",  a_oe,  e.a_oe);
        cmp(e.tag, "clash", {{(W-1){1'b0}}, clash}, {{(W-1){1'b0}}, e.clash});
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    // reset, all quiet (R3)
    step(1, 1,1,1, 1,1,1, 8'h00, 8'h00, "R3_reset_quiet");
    step(1, 1,1,1, 1,1,1, 8'h00, 8'h00, "R3_reset_quiet");
    // R1 cleared banks shown while both drive; R9 clash
    step(0, 0,1,0, 0,1,0, 8'h77, 8'h66, "R1_R9_cleared_and_clash");
    // R4 flow-through, two patterns
    step(0, 0,0,0, 1,1,1, 8'h3C, 8'h00, "R4_flow");
    step(0, 0,0,0, 1,1,1, 8'hA5, 8'h00, "R4_flow");
    // R5 load rises, new data ignored
    step(0, 0,1,0, 1,1,1, 8'h0F, 8'h00, "R5_capture");
    step(0, 0,1,0, 1,1,1, 8'hFF, 8'h00, "R6_hold");
    // R3 and R10: drive off
    step(0, 0,1,1, 1,1,1, 8'hFF, 8'h00, "R3_R10_drive_off");
    // R2 bank disabled, load low, data moving
    step(0, 1,0,0, 1,1,1, 8'h11, 8'h00, "R2_disabled");
    step(0, 1,0,0, 1,1,1, 8'h22, 8'h00, "R2_disabled");
    // R7 driving stored value after disable
    step(0, 0,1,0, 1,1,1, 8'h99, 8'h00, "R7_R2_stored_kept");
    // R8 mirror direction
    step(0, 1,1,1, 0,0,0, 8'h00, 8'h5A, "R8_flow");
    step(0, 1,1,1, 0,1,0, 8'h00, 8'h00, "R8_capture");
    step(0, 1,1,1, 0,1,0, 8'h00, 8'hC3, "R8_hold");
    step(0, 1,1,1, 1,0,0, 8'h00, 8'h81, "R8_disabled");
    step(0, 1,1,1, 0,1,1, 8'h00, 8'h81, "R8_R10_drive_off");
    // R9 both drive, then one stops
    step(0, 0,1,0, 0,1,0, 8'h00, 8'h00, "R9_clash");
    step(0, 0,1,1, 0,1,0, 8'h00, 8'h00, "R9_no_clash");
    // R4 flow in both directions at once with clash
    step(0, 0,0,0, 0,0,0, 8'h12, 8'h34, "R4_R8_R9_both_flow");
    // R1 reset mid-run clears, then check
    step(1, 1,1,1, 1,1,1, 8'h00, 8'h00, "R1_reset_again");
    step(0, 0,1,0, 0,1,0, 8'h00, 8'h00, "R1_cleared");
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule